// File: doc/BRIEF.md
# Signed 64-by-32 Division Unit

This block is a register-mapped signed divider. Software loads a 32-bit divisor, then starts a division by writing a dividend register. A write to the single-word dividend register runs a 32-by-32 divide. A write to the low half of the double-word dividend runs a 64-by-32 divide of the pair {high half, low half}. The high half is whatever was last stored there.

The arithmetic is a sequential restoring loop that works on magnitudes. One quotient bit is produced per clock, and sign correction is applied at the end. While the loop runs, a busy output is high and every write is dropped. When the loop finishes, the quotient and remainder are written into the dividend registers and into two mirror registers in a single cycle. A quotient that cannot be held in a signed 32-bit word is clamped to the nearest extreme. A zero divisor does no arithmetic and clears the result registers at once.

Top module: `sdiv_unit`

## Requirements
- R1: After a synchronous reset, every register reads as zero and busy is low.
- R2: A read enabled in one cycle presents the stored word on rdata after the next rising edge. Byte offsets 0x08 and 0x0C hold nothing and always read zero. A read during busy returns the value currently stored.
- R3: Writing offset 0x04 with a nonzero divisor at 0x00 starts a 32-by-32 divide of the written word. On completion, the quotient lands in 0x04, 0x14 and 0x1C, and the remainder lands in 0x10 and 0x18.
- R4: Writing offset 0x14 with a nonzero divisor divides the 64-bit value {0x10, written word}. On completion, the quotient goes to 0x14 and 0x1C and the remainder to 0x10 and 0x18. Offset 0x04 is left unchanged.
- R5: The quotient truncates toward zero. A nonzero remainder carries the sign of the dividend, and its magnitude is below that of the divisor.
- R6: A quotient above 2^31-1 stores as 0x7FFFFFFF, and one below -2^31 stores as 0x80000000; the remainder is still the exact remainder. This includes 0x80000000 divided by -1 in the 32-bit mode.
- R7: A start write while the divisor is zero sets 0x04, 0x10, 0x14, 0x18 and 0x1C to zero on that clock edge, and busy stays low.
- R8: busy rises the cycle after an accepted start and stays high for exactly 2*W+1 cycles. Results are readable once it falls.
- R9: Every write that arrives while busy is high is ignored, including writes to the divisor and further start writes.
- R10: Writes to 0x00, 0x10, 0x18 and 0x1C only store the word and never start a divide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe; rdata updates on the next edge |
| addr | input | ADDR_W (5) | Byte offset within the unit; bits [4:2] select the word |
| wdata | input | W (32) | Write data |
| rdata | output | W (32) | Registered read data |
| busy | output | 1 | High while a divide is in progress |

## Verification
The bench builds the unit with its default parameters: W = 32 and ADDR_W = 5. That gives 64 loop iterations, so every busy window lasts 65 cycles. With these values the exact saturation limits 0x7FFFFFFF and 0x80000000 can be reached. So can the boundary quotients that just fit against those that just overflow, and the most negative single-word dividend divided by -1. A behavioural model compares busy on every clock and rdata after every read. The model is built on native 64-bit integer division, including randomised 64-by-32 operands.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  // word indices (byte offset >> 2); the map is software-visible
  localparam int unsigned IDX_DIVISOR = 0;
  localparam int unsigned IDX_DVD32   = 1;
  localparam int unsigned IDX_DVD_HI  = 4;
  localparam int unsigned IDX_DVD_LO  = 5;
  localparam int unsigned IDX_MIR_HI  = 6;
  localparam int unsigned IDX_MIR_LO  = 7;

  typedef enum logic {
    MODE_32 = 1'b0,
    MODE_64 = 1'b1
  } div_mode_e;
endpackage

// File: rtl/sdiv_regs.sv
module sdiv_regs
  import sdiv_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic              lock,
  input  logic              wb_en,
  input  div_mode_e         wb_mode,
  input  logic [W-1:0]      wb_quo,
  input  logic [W-1:0]      wb_rem,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      divisor,
  output logic [W-1:0]      dvd_hi,
  output logic              start32,
  output logic              start64
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             wr_ok;
  logic             div_zero;
  logic [W-1:0]     r_div, r_d32, r_hi, r_lo, r_mhi, r_mlo;
  logic [W-1:0]     rd_mux;
  logic             unused_addr;

  assign idx         = addr[ADDR_W-1:2];
  assign unused_addr = ^addr[1:0];
  assign wr_ok       = wr_en && !lock;
  assign div_zero    = (r_div == '0);
  assign start32     = wr_ok && (idx == IDX_W'(IDX_DVD32));
  assign start64     = wr_ok && (idx == IDX_W'(IDX_DVD_LO));

  always_comb begin
    rd_mux = '0;
    case (idx)
      IDX_W'(IDX_DIVISOR): rd_mux = r_div;
      IDX_W'(IDX_DVD32):   rd_mux = r_d32;
      IDX_W'(IDX_DVD_HI):  rd_mux = r_hi;
      IDX_W'(IDX_DVD_LO):  rd_mux = r_lo;
      IDX_W'(IDX_MIR_HI):  rd_mux = r_mhi;
      IDX_W'(IDX_MIR_LO):  rd_mux = r_mlo;
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      r_div <= '0;
      r_d32 <= '0;
      r_hi  <= '0;
      r_lo  <= '0;
      r_mhi <= '0;
      r_mlo <= '0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      if (wb_en) begin
        r_hi  <= wb_rem;
        r_mhi <= wb_rem;
        r_lo  <= wb_quo;
        r_mlo <= wb_quo;
        if (wb_mode == MODE_32) r_d32 <= wb_quo;
      end else if (wr_ok) begin
        case (idx)
          IDX_W'(IDX_DIVISOR): r_div <= wdata;
          IDX_W'(IDX_DVD_HI):  r_hi  <= wdata;
          IDX_W'(IDX_MIR_HI):  r_mhi <= wdata;
          IDX_W'(IDX_MIR_LO):  r_mlo <= wdata;
          IDX_W'(IDX_DVD32), IDX_W'(IDX_DVD_LO): begin
            if (div_zero) begin
              r_d32 <= '0;
              r_hi  <= '0;
              r_lo  <= '0;
              r_mhi <= '0;
              r_mlo <= '0;
            end else if (idx == IDX_W'(IDX_DVD32)) begin
              r_d32 <= wdata;
            end else begin
              r_lo <= wdata;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign divisor = r_div;
  assign dvd_hi  = r_hi;

  // R7: a start against a zero divisor leaves the mirrors cleared
  p_zero_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (start32 || start64) && div_zero |=> (r_mhi == '0) && (r_mlo == '0));
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [2*W-1:0] dvd_mag,
  input  logic [W-1:0]   dvs_mag,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] q_mag,
  output logic [W-1:0]   r_mag
);
  localparam int QW    = 2 * W;
  localparam int ITERS = QW;
  localparam int CNT_W = $clog2(ITERS);

  logic             run_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [QW-1:0]    quo_q;
  logic [W-1:0]     rem_q, dvs_q;
  logic [W:0]       rem_shift, rem_next;
  logic             fits;
  logic             unused_top;

  assign rem_shift  = {rem_q, quo_q[QW-1]};
  assign fits       = rem_shift >= {1'b0, dvs_q};
  assign rem_next   = fits ? (rem_shift - {1'b0, dvs_q}) : rem_shift;
  assign unused_top = rem_next[W];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !run_q && !done_q) begin
        run_q <= 1'b1;
        cnt_q <= '0;
        quo_q <= dvd_mag;
        rem_q <= '0;
        dvs_q <= dvs_mag;
      end else if (run_q) begin
        quo_q <= {quo_q[QW-2:0], fits};
        rem_q <= rem_next[W-1:0];
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(ITERS - 1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy  = run_q | done_q;
  assign done  = done_q;
  assign q_mag = quo_q;
  assign r_mag = rem_q;

  // R5: the partial remainder always stays below the divisor magnitude
  p_partial_lt_r5: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (rem_q < dvs_q));
  // R8: a running loop finishes with a single completion pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q && !run_q);
endmodule

// File: rtl/sdiv_fixup.sv
module sdiv_fixup #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] q_mag,
  input  logic [W-1:0]   r_mag,
  input  logic           neg_q,
  input  logic           neg_r,
  output logic [W-1:0]   quo,
  output logic [W-1:0]   rem,
  output logic           ovf
);
  localparam logic [2*W-1:0] POS_LIM = {{(W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic [2*W-1:0] NEG_LIM = {{W{1'b0}}, 1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0]   SAT_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0]   SAT_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0]   ONE     = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    ovf = neg_q ? (q_mag > NEG_LIM) : (q_mag > POS_LIM);
    if (ovf)        quo = neg_q ? SAT_NEG : SAT_POS;
    else if (neg_q) quo = (~q_mag[W-1:0]) + ONE;
    else            quo = q_mag[W-1:0];
    rem = neg_r ? ((~r_mag) + ONE) : r_mag;
  end
endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit
  import sdiv_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic              busy
);
  localparam int QW = 2 * W;

  logic [W-1:0]  divisor_w, dvd_hi_w, quo_w, rem_w;
  logic          start32, start64, start_core;
  logic          core_busy, core_done, ovf_w;
  logic [QW-1:0] dvd_full, dvd_abs, q_mag;
  logic [W-1:0]  dvs_abs, r_mag;
  logic          dvd_neg;
  logic          neg_q_q, neg_r_q;
  div_mode_e     mode_q;

  assign dvd_full   = start64 ? {dvd_hi_w, wdata} : {{W{wdata[W-1]}}, wdata};
  assign dvd_neg    = dvd_full[QW-1];
  assign dvd_abs    = dvd_neg ? ((~dvd_full) + {{(QW-1){1'b0}}, 1'b1}) : dvd_full;
  assign dvs_abs    = divisor_w[W-1] ? ((~divisor_w) + {{(W-1){1'b0}}, 1'b1}) : divisor_w;
  assign start_core = (start32 || start64) && (divisor_w != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      neg_q_q <= 1'b0;
      neg_r_q <= 1'b0;
      mode_q  <= MODE_32;
    end else if (start_core) begin
      neg_q_q <= dvd_neg ^ divisor_w[W-1];
      neg_r_q <= dvd_neg;
      mode_q  <= start64 ? MODE_64 : MODE_32;
    end
  end

  sdiv_regs #(.W(W), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .lock    (core_busy),
    .wb_en   (core_done),
    .wb_mode (mode_q),
    .wb_quo  (quo_w),
    .wb_rem  (rem_w),
    .rdata   (rdata),
    .divisor (divisor_w),
    .dvd_hi  (dvd_hi_w),
    .start32 (start32),
    .start64 (start64)
  );

  sdiv_core #(.W(W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .start   (start_core),
    .dvd_mag (dvd_abs),
    .dvs_mag (dvs_abs),
    .busy    (core_busy),
    .done    (core_done),
    .q_mag   (q_mag),
    .r_mag   (r_mag)
  );

  sdiv_fixup #(.W(W)) u_fix (
    .q_mag (q_mag),
    .r_mag (r_mag),
    .neg_q (neg_q_q),
    .neg_r (neg_r_q),
    .quo   (quo_w),
    .rem   (rem_w),
    .ovf   (ovf_w)
  );

  assign busy = core_busy;

  // R9: the divisor cannot change while a divide is running
  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
    busy && wr_en |=> $stable(divisor_w));
  // R7: a zero divisor never raises busy
  p_zero_div_r7: assert property (@(posedge clk) disable iff (rst)
    (start32 || start64) && (divisor_w == '0) |=> !busy);
  // R8: an accepted start raises busy on the next cycle
  p_start_busy_r8: assert property (@(posedge clk) disable iff (rst)
    start_core |=> busy);
  // R5: a nonzero remainder follows the dividend sign
  p_rem_sign_r5: assert property (@(posedge clk) disable iff (rst)
    core_done && (rem_w != '0) |-> (rem_w[W-1] == neg_r_q));
  // R6: an overflowing quotient is stored at an extreme
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    core_done && ovf_w |=> (dvd_hi_w == $past(rem_w)) &&
      ((u_regs.r_lo == {1'b0, {(W-1){1'b1}}}) || (u_regs.r_lo == {1'b1, {(W-1){1'b0}}})));
endmodule

// File: tb/sdiv_unit_tb_top.sv
`timescale 1ns/1ps
module sdiv_unit_tb_top;
  localparam int W      = 32;
  localparam int ADDR_W = 5;
  localparam int ITERS  = 2 * W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [W-1:0]      wdata = '0;
  logic [W-1:0]      rdata;
  logic              busy;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  sdiv_unit #(.W(W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_reg [8];
  int          m_cnt = 0;
  logic [31:0] m_rd = '0;
  bit          rd_seen = 0;
  logic [31:0] p_q, p_r;
  bit          p_64;

  function automatic void compute(longint n, longint dv);
    longint q, r;
    if (n == 64'sh8000000000000000 && dv == -1) begin
      p_q = 32'h7fffffff; p_r = 0;
    end else begin
      q = n / dv;
      r = n % dv;
      if (q > 64'sd2147483647)       p_q = 32'h7fffffff;
      else if (q < -64'sd2147483648) p_q = 32'h80000000;
      else                           p_q = q[31:0];
      p_r = r[31:0];
    end
  endfunction

  function automatic void model_write(int i, logic [31:0] d);
    case (i)
      0, 4, 6, 7: m_reg[i] = d;
      1, 5: begin
        if (m_reg[0] == 0) begin
          m_reg[1] = 0; m_reg[4] = 0; m_reg[5] = 0; m_reg[6] = 0; m_reg[7] = 0;
        end else begin
          p_64 = (i == 5);
          if (p_64) compute(longint'({m_reg[4], d}), longint'(int'(m_reg[0])));
          else      compute(longint'(int'(d)), longint'(int'(m_reg[0])));
          m_reg[i] = d;
          m_cnt = ITERS + 1;
        end
      end
      default: ;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) m_reg[i] = 0;
      m_cnt = 0; m_rd = 0; rd_seen = 0;
    end else begin
      rd_seen = rd_en;
      if (rd_en) m_rd = (addr[4:2] == 2 || addr[4:2] == 3) ? 32'h0 : m_reg[addr[4:2]];
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_reg[4] = p_r; m_reg[6] = p_r; m_reg[5] = p_q; m_reg[7] = p_q;
          if (!p_64) m_reg[1] = p_q;
        end
      end else if (wr_en) begin
        model_write(int'(addr[4:2]), wdata);
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      n_chk++;
      if (busy !== (m_cnt != 0)) begin
        n_fail++;
        $display("FAIL R8 busy actual=%b expected=%b", busy, (m_cnt != 0));
      end
      if (rd_seen) begin
        n_chk++;
        if (rdata !== m_rd) begin
          n_fail++;
          $display("FAIL R2 (%s) model read actual=%h expected=%h", tag, rdata, m_rd);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [4:0] off, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = off; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_cnt != 0) @(negedge clk);
  endtask

  task automatic check_reg(input logic [4:0] off, input logic [31:0] exp, input string t);
    tag = t;
    @(negedge clk);
    rd_en = 1'b1; addr = off;
    @(negedge clk);
    rd_en = 1'b0;
    n_chk++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s off=%h actual=%h expected=%h", t, off, rdata, exp);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    for (int o = 0; o < 8; o++) check_reg(5'(o * 4), 32'h0, "R1");
    // R10: plain stores never start
    wr(5'h00, 32'd7);
    wr(5'h10, 32'h1234);
    wr(5'h18, 32'h55);
    check_reg(5'h10, 32'h1234, "R10");
    check_reg(5'h18, 32'h55, "R10");
    // R2: unmapped words read zero
    wr(5'h08, 32'hdead);
    check_reg(5'h08, 32'h0, "R2");
    check_reg(5'h0C, 32'h0, "R2");
    // R3: 32/32 divide
    wr(5'h04, 32'd100);
    check_reg(5'h04, 32'd100, "R2");
    wait_idle();
    check_reg(5'h04, 32'd14, "R3");
    check_reg(5'h14, 32'd14, "R3");
    check_reg(5'h1C, 32'd14, "R3");
    check_reg(5'h10, 32'd2, "R3");
    check_reg(5'h18, 32'd2, "R3");
    // R5: sign rules
    wr(5'h04, -32'sd100); wait_idle();
    check_reg(5'h04, 32'hfffffff2, "R5");
    check_reg(5'h10, 32'hfffffffe, "R5");
    wr(5'h00, -32'sd7);
    wr(5'h04, 32'd100); wait_idle();
    check_reg(5'h04, 32'hfffffff2, "R5");
    check_reg(5'h10, 32'd2, "R5");
    // R4: 64/32 divide, 0x04 untouched
    wr(5'h00, 32'd16);
    wr(5'h10, 32'd1);
    wr(5'h14, 32'd0); wait_idle();
    check_reg(5'h14, 32'h10000000, "R4");
    check_reg(5'h1C, 32'h10000000, "R4");
    check_reg(5'h10, 32'h0, "R4");
    check_reg(5'h04, 32'hfffffff2, "R4");
    wr(5'h00, 32'd7);
    wr(5'h10, 32'hffffffff);
    wr(5'h14, 32'hffffff9c); wait_idle();
    check_reg(5'h14, 32'hfffffff2, "R4");
    check_reg(5'h18, 32'hfffffffe, "R5");
    // R6: saturation and boundaries
    wr(5'h00, 32'd2);
    wr(5'h10, 32'd7);
    wr(5'h14, 32'd1); wait_idle();
    check_reg(5'h14, 32'h7fffffff, "R6");
    check_reg(5'h10, 32'd1, "R6");
    wr(5'h00, -32'sd2);
    wr(5'h10, 32'd7);
    wr(5'h14, 32'd0); wait_idle();
    check_reg(5'h1C, 32'h80000000, "R6");
    wr(5'h00, 32'd2);
    wr(5'h10, 32'd0);
    wr(5'h14, 32'hfffffffe); wait_idle();
    check_reg(5'h14, 32'h7fffffff, "R6");
    wr(5'h00, 32'd1);
    wr(5'h10, 32'd0);
    wr(5'h14, 32'h80000000); wait_idle();
    check_reg(5'h14, 32'h7fffffff, "R6");
    wr(5'h00, 32'hffffffff);
    wr(5'h04, 32'h80000000); wait_idle();
    check_reg(5'h04, 32'h7fffffff, "R6");
    check_reg(5'h10, 32'h0, "R6");
    // R7: zero divisor
    wr(5'h00, 32'd0);
    wr(5'h04, 32'd55);
    check_reg(5'h04, 32'h0, "R7");
    check_reg(5'h1C, 32'h0, "R7");
    wr(5'h10, 32'd9);
    wr(5'h14, 32'd9);
    check_reg(5'h10, 32'h0, "R7");
    // R9: writes during busy ignored; R2 read while busy
    wr(5'h00, 32'd7);
    wr(5'h04, 32'd100);
    wr(5'h00, 32'd3);
    wr(5'h04, 32'd9);
    wr(5'h14, 32'd9);
    check_reg(5'h04, 32'd100, "R2");
    wait_idle();
    check_reg(5'h00, 32'd7, "R9");
    check_reg(5'h04, 32'd14, "R9");
    // R8 and R5: randomised 64/32 divides against the model
    for (int k = 0; k < 16; k++) begin
      logic [31:0] dv, hi, lo;
      dv = $urandom;
      if (k % 3 == 0) dv = {{28{dv[3]}}, dv[3:0]};
      if (dv == 0) dv = 32'd5;
      hi = $urandom;
      if (k % 2 == 0) hi = {{30{hi[31]}}, hi[1:0]};
      lo = $urandom;
      wr(5'h00, dv);
      wr(5'h10, hi);
      wr(5'h14, lo); wait_idle();
      check_reg(5'h14, m_reg[5], "R8");
      check_reg(5'h10, m_reg[4], "R5");
    end
    finish_run();
  end
endmodule